// File: doc/BRIEF.md
# Radix Translation Tree Walker

This block turns an effective address into a real address by walking a radix tree held in memory. The caller gives it three things: the base of the root table, the index width used at the root, and the number of address bits that the tree covers. It then reads one 64-bit entry per level. An entry can point one level further down, and in that case it also names the index width for that level, so the page size shrinks at each step. An entry can also be a leaf, which ends the walk. A leaf can sit at any depth.

When the walk reaches a leaf, the block returns four results: the real address, the page size in bits, the leaf entry and the memory address the leaf was read from. The entry and its address allow a later reference/change update. If the walk cannot finish, the block returns a fault with a cause vector. All results appear together with a one-cycle done pulse, and the block makes only one memory read at a time.

Entry layout used throughout:
- bit 63 is valid.
- bit 62 is leaf.
- For a pointer entry, bits [PA_W-1:8] are the next table base, with the low 8 bits taken as zero, and bits [4:0] are the next index width.
- For a leaf, bits [PA_W-1:12] are the page number.

Top module: `rpw_walker`

## Requirements
- R1: A start while idle whose root index width is below 5, or larger than the covered size, ends the walk with no memory read. One cycle after start, done rises with fault set and cause 3'b001 (bit 0 is bad configuration).
- R2: Each read goes to table base + 8 × ((ea >> (remaining − width)) mod 2^width). The low 3 bits of the root base are treated as zero. rd_req stays high with a stable rd_addr until rd_valid returns the data, and only one read is in flight at a time.
- R3: A read entry with bit 63 clear ends the walk with fault and cause 3'b010 (bit 1 is no entry).
- R4: After each entry is read, the remaining size drops by the width just used. A valid entry with bit 62 clear supplies the next base and the next width from its fields.
- R5: A pointer entry whose index width is below 5, or larger than the remaining size, ends the walk with fault and cause 3'b001.
- R6: At a leaf, real_addr is the page number with its low (remaining) bits cleared, ORed with those same low bits of ea. page_size is the remaining size.
- R7: At a leaf, leaf_entry holds the entry read and leaf_addr holds the address it was read from. Fault is low and cause is 3'b000.
- R8: If 8 reads in a row all return pointer entries, the walk ends with fault and cause 3'b100 (bit 2 is depth).
- R9: Done is high for exactly one cycle per walk. On a fault, exactly one cause bit is set.
- R10: A start that arrives while a walk is in progress is ignored and does not change that walk's result.
- R11: Bits of ea at or above the covered size do not affect the result.
- R12: After reset the block is idle, with busy, done and rd_req all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| ea | input | EA_W | Effective address to translate |
| root_base | input | PA_W | Root table base address |
| root_nls | input | 5 | Root index width in bits |
| total_bits | input | $clog2(EA_W+1) | Address bits covered by the tree |
| rd_req | output | 1 | Memory read request, held until rd_valid |
| rd_addr | output | PA_W | Address of the entry being read |
| rd_valid | input | 1 | Read data valid; completes the read |
| rd_data | input | 64 | Entry returned by memory |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when the walk ends |
| fault | output | 1 | Walk ended without a leaf |
| cause | output | 3 | Fault cause: bit 0 bad configuration, bit 1 no entry, bit 2 depth |
| real_addr | output | PA_W | Translated address |
| page_size | output | $clog2(EA_W+1) | Page size in bits |
| leaf_entry | output | 64 | Leaf entry that was read |
| leaf_addr | output | PA_W | Address of the leaf entry |

## Verification
A corrupted remaining size or level width shows at the ports on the very next read. The rd_addr of that read points to the wrong slot, so the wrong entry is fetched, and the bench sees a wrong leaf_addr, real_addr or page_size when done pulses, a few cycles later. A level counter that is off changes the number of reads before a depth fault, and the bench compares that read count on every walk. A state register stuck busy stops done from ever rising, and the watchdog reports it.

// File: rtl/rpw_pkg.sv
package rpw_pkg;
    localparam int ENTRY_W  = 64;
    localparam int V_BIT    = 63;
    localparam int L_BIT    = 62;
    localparam int NLS_FW   = 5;
    localparam int NB_LSB   = 8;
    localparam int PG_LSB   = 12;
    localparam int MIN_NLS  = 5;
    localparam int CAUSE_W  = 3;
    localparam int C_BADCFG = 0;
    localparam int C_NOENT  = 1;
    localparam int C_DEPTH  = 2;

    typedef enum logic [0:0] {
        WALK_IDLE  = 1'b0,
        WALK_FETCH = 1'b1
    } walk_st_e;
endpackage

// File: rtl/rpw_cfg_check.sv
module rpw_cfg_check
    import rpw_pkg::*;
#(
    parameter int SIZE_W = 7
) (
    input  logic [NLS_FW-1:0] nls,
    input  logic [SIZE_W-1:0] rem,
    output logic              ok
);
    logic [SIZE_W-1:0] nls_ext;

    always_comb begin
        nls_ext = SIZE_W'(nls);
        ok      = (nls_ext >= SIZE_W'(MIN_NLS)) && (nls_ext <= rem);
    end
endmodule

// File: rtl/rpw_index_addr.sv
module rpw_index_addr
    import rpw_pkg::*;
#(
    parameter int EA_W   = 64,
    parameter int PA_W   = 56,
    parameter int SIZE_W = 7
) (
    input  logic [EA_W-1:0]   ea,
    input  logic [PA_W-1:0]   base,
    input  logic [SIZE_W-1:0] rem,
    input  logic [NLS_FW-1:0] nls,
    output logic [PA_W-1:0]   entry_addr
);
    logic [SIZE_W-1:0] shift_amt;
    logic [EA_W-1:0]   field_mask;
    logic [EA_W-1:0]   idx;
    logic [EA_W-1:0]   byte_off;
    logic [PA_W-1:0]   base_al;
    logic              unused_base_lo;

    always_comb begin
        shift_amt  = rem - SIZE_W'(nls);
        field_mask = ~({EA_W{1'b1}} << nls);
        idx        = (ea >> shift_amt) & field_mask;
        byte_off   = idx << 3;
        base_al    = {base[PA_W-1:3], 3'b000};
        entry_addr = base_al + byte_off[PA_W-1:0];
    end

    assign unused_base_lo = ^base[2:0];
endmodule

// File: rtl/rpw_leaf_addr.sv
module rpw_leaf_addr
    import rpw_pkg::*;
#(
    parameter int EA_W   = 64,
    parameter int PA_W   = 56,
    parameter int SIZE_W = 7
) (
    input  logic [PA_W-PG_LSB-1:0] rpn_field,
    input  logic [EA_W-1:0]        ea,
    input  logic [SIZE_W-1:0]      psize,
    output logic [PA_W-1:0]        real_addr
);
    logic [EA_W-1:0] rpn;
    logic [EA_W-1:0] off_mask;
    logic [EA_W-1:0] full;
    logic            unused_hi;

    always_comb begin
        rpn                    = '0;
        rpn[PA_W-1:PG_LSB]     = rpn_field;
        off_mask               = ~({EA_W{1'b1}} << psize);
        full                   = (rpn & ~off_mask) | (ea & off_mask);
        real_addr              = full[PA_W-1:0];
    end

    assign unused_hi = ^full[EA_W-1:PA_W];
endmodule

// File: rtl/rpw_walker.sv
module rpw_walker
    import rpw_pkg::*;
#(
    parameter int EA_W       = 64,
    parameter int PA_W       = 56,
    parameter int MAX_LEVELS = 8,
    localparam int SIZE_W    = $clog2(EA_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [EA_W-1:0]     ea,
    input  logic [PA_W-1:0]     root_base,
    input  logic [NLS_FW-1:0]   root_nls,
    input  logic [SIZE_W-1:0]   total_bits,
    output logic                rd_req,
    output logic [PA_W-1:0]     rd_addr,
    input  logic                rd_valid,
    input  logic [ENTRY_W-1:0]  rd_data,
    output logic                busy,
    output logic                done,
    output logic                fault,
    output logic [CAUSE_W-1:0]  cause,
    output logic [PA_W-1:0]     real_addr,
    output logic [SIZE_W-1:0]   page_size,
    output logic [ENTRY_W-1:0]  leaf_entry,
    output logic [PA_W-1:0]     leaf_addr
);
    localparam int LVL_W = $clog2(MAX_LEVELS + 1);

    typedef struct packed {
        walk_st_e            st;
        logic [EA_W-1:0]     ea;
        logic [PA_W-1:0]     addr;
        logic [SIZE_W-1:0]   rem;
        logic [NLS_FW-1:0]   nls;
        logic [LVL_W-1:0]    lvl;
        logic                done;
        logic                fault;
        logic [CAUSE_W-1:0]  cause;
        logic [PA_W-1:0]     ra;
        logic [SIZE_W-1:0]   psize;
        logic [ENTRY_W-1:0]  leaf;
        logic [PA_W-1:0]     leaf_addr;
    } walk_reg_t;

    walk_reg_t r_q, r_d;

    logic [PA_W-1:0]   child_base;
    logic [NLS_FW-1:0] child_nls;
    logic [SIZE_W-1:0] rem_after;
    logic [LVL_W-1:0]  lvl_next;
    logic [EA_W-1:0]   calc_ea;
    logic [PA_W-1:0]   calc_base;
    logic [SIZE_W-1:0] calc_rem;
    logic [NLS_FW-1:0] calc_nls;
    logic [PA_W-1:0]   calc_addr;
    logic              root_ok;
    logic              child_ok;
    logic [PA_W-1:0]   leaf_ra;
    logic              unused_entry_bits;

    // Fields of a pointer entry and the remaining size after this level.
    always_comb begin
        child_base                    = '0;
        child_base[PA_W-1:NB_LSB]     = rd_data[PA_W-1:NB_LSB];
        child_nls                     = rd_data[NLS_FW-1:0];
        rem_after                     = r_q.rem - SIZE_W'(r_q.nls);
        lvl_next                      = r_q.lvl + LVL_W'(1);
    end

    // One index unit is shared: root values while idle, child values while fetching.
    always_comb begin
        if (r_q.st == WALK_IDLE) begin
            calc_ea   = ea;
            calc_base = root_base;
            calc_rem  = total_bits;
            calc_nls  = root_nls;
        end else begin
            calc_ea   = r_q.ea;
            calc_base = child_base;
            calc_rem  = rem_after;
            calc_nls  = child_nls;
        end
    end

    rpw_index_addr #(.EA_W(EA_W), .PA_W(PA_W), .SIZE_W(SIZE_W)) idx_i (
        .ea         (calc_ea),
        .base       (calc_base),
        .rem        (calc_rem),
        .nls        (calc_nls),
        .entry_addr (calc_addr)
    );

    rpw_cfg_check #(.SIZE_W(SIZE_W)) root_chk_i (
        .nls (root_nls),
        .rem (total_bits),
        .ok  (root_ok)
    );

    rpw_cfg_check #(.SIZE_W(SIZE_W)) child_chk_i (
        .nls (child_nls),
        .rem (rem_after),
        .ok  (child_ok)
    );

    rpw_leaf_addr #(.EA_W(EA_W), .PA_W(PA_W), .SIZE_W(SIZE_W)) leaf_i (
        .rpn_field (rd_data[PA_W-1:PG_LSB]),
        .ea        (r_q.ea),
        .psize     (rem_after),
        .real_addr (leaf_ra)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            WALK_IDLE: begin
                if (start) begin
                    r_d.ea    = ea;
                    r_d.fault = 1'b0;
                    r_d.cause = '0;
                    if (!root_ok) begin
                        r_d.done             = 1'b1;
                        r_d.fault            = 1'b1;
                        r_d.cause[C_BADCFG]  = 1'b1;
                    end else begin
                        r_d.st   = WALK_FETCH;
                        r_d.addr = calc_addr;
                        r_d.rem  = total_bits;
                        r_d.nls  = root_nls;
                        r_d.lvl  = '0;
                    end
                end
            end
            WALK_FETCH: begin
                if (rd_valid) begin
                    r_d.lvl = lvl_next;
                    if (!rd_data[V_BIT]) begin
                        r_d.st              = WALK_IDLE;
                        r_d.done            = 1'b1;
                        r_d.fault           = 1'b1;
                        r_d.cause[C_NOENT]  = 1'b1;
                    end else if (rd_data[L_BIT]) begin
                        r_d.st        = WALK_IDLE;
                        r_d.done      = 1'b1;
                        r_d.ra        = leaf_ra;
                        r_d.psize     = rem_after;
                        r_d.leaf      = rd_data;
                        r_d.leaf_addr = r_q.addr;
                    end else if (!child_ok) begin
                        r_d.st              = WALK_IDLE;
                        r_d.done            = 1'b1;
                        r_d.fault           = 1'b1;
                        r_d.cause[C_BADCFG] = 1'b1;
                    end else if (lvl_next == LVL_W'(MAX_LEVELS)) begin
                        r_d.st              = WALK_IDLE;
                        r_d.done            = 1'b1;
                        r_d.fault           = 1'b1;
                        r_d.cause[C_DEPTH]  = 1'b1;
                    end else begin
                        r_d.addr = calc_addr;
                        r_d.rem  = rem_after;
                        r_d.nls  = child_nls;
                    end
                end
            end
            default: r_d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req     = (r_q.st == WALK_FETCH);
    assign rd_addr    = r_q.addr;
    assign busy       = (r_q.st != WALK_IDLE);
    assign done       = r_q.done;
    assign fault      = r_q.fault;
    assign cause      = r_q.cause;
    assign real_addr  = r_q.ra;
    assign page_size  = r_q.psize;
    assign leaf_entry = r_q.leaf;
    assign leaf_addr  = r_q.leaf_addr;

    assign unused_entry_bits = ^{rd_data[ENTRY_W-3:PA_W], rd_data[NB_LSB-1:NLS_FW]};
endmodule

// File: rtl/rpw_walker_chk.sv
module rpw_walker_chk
    import rpw_pkg::*;
#(
    parameter int EA_W       = 64,
    parameter int PA_W       = 56,
    parameter int MAX_LEVELS = 8,
    localparam int SIZE_W    = $clog2(EA_W + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic [NLS_FW-1:0]   root_nls,
    input logic [SIZE_W-1:0]   total_bits,
    input logic                rd_req,
    input logic                rd_valid,
    input logic [PA_W-1:0]     rd_addr,
    input logic                done,
    input logic                fault,
    input logic [CAUSE_W-1:0]  cause,
    input logic [SIZE_W-1:0]   page_size,
    input logic [ENTRY_W-1:0]  leaf_entry
);
    logic [7:0]        rd_cnt;
    logic [SIZE_W-1:0] tot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            tot_q  <= '0;
        end else if (start && !busy) begin
            rd_cnt <= '0;
            tot_q  <= total_bits;
        end else if (rd_req && rd_valid) begin
            rd_cnt <= rd_cnt + 8'd1;
        end
    end

    assert_root_badcfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && ((SIZE_W'(root_nls) < SIZE_W'(MIN_NLS)) || (SIZE_W'(root_nls) > total_bits))
        |=> done && fault && (cause == 3'b001) && !rd_req);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

    assert_psize_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault && !busy |-> page_size <= tot_q);

    assert_leaf_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> leaf_entry[V_BIT] && leaf_entry[L_BIT] && (cause == '0));

    assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= 8'(MAX_LEVELS));

    assert_cause_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> $countones(cause) == 1);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);
endmodule

bind rpw_walker rpw_walker_chk #(
    .EA_W(EA_W), .PA_W(PA_W), .MAX_LEVELS(MAX_LEVELS)
) chk_i (.*);

// File: tb/rpw_walker_tb_top.sv
module rpw_walker_tb_top;
    localparam int CLK_T = 10;

    typedef struct packed {
        logic [63:0] ea;
        logic [55:0] base;
        logic [4:0]  nls;
        logic [6:0]  total;
        logic        flt;
        logic [2:0]  cause;
        logic [55:0] ra;
        logic [6:0]  psize;
        logic [55:0] laddr;
        logic [63:0] lent;
        logic [3:0]  nrd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R4 R6 R7: two levels, 4 KiB page
        '{64'h605456, 56'h1000, 5'd9, 7'd30, 1'b0, 3'b000, 56'hABCDE456, 7'd12, 56'h2028, 64'hC000_0000_ABCD_E000, 4'd2},
        // R6: leaf at root, low page-number bits cleared
        '{64'hFABCDE, 56'h1000, 5'd9, 7'd30, 1'b0, 3'b000, 56'h123ABCDE, 7'd21, 56'h1038, 64'hC000_0000_1234_5000, 4'd1},
        // R3: root entry invalid
        '{64'h200000, 56'h1000, 5'd9, 7'd30, 1'b1, 3'b010, 56'h0, 7'd0, 56'h0, 64'h0, 4'd1},
        // R3: second-level entry invalid
        '{64'h606000, 56'h1000, 5'd9, 7'd30, 1'b1, 3'b010, 56'h0, 7'd0, 56'h0, 64'h0, 4'd2},
        // R5: child width 4
        '{64'h800000, 56'h1000, 5'd9, 7'd30, 1'b1, 3'b001, 56'h0, 7'd0, 56'h0, 64'h0, 4'd1},
        // R5: child width 22 above remaining 21
        '{64'hA00000, 56'h1000, 5'd9, 7'd30, 1'b1, 3'b001, 56'h0, 7'd0, 56'h0, 64'h0, 4'd1},
        // R1: root width 4
        '{64'h0, 56'h1000, 5'd4, 7'd30, 1'b1, 3'b001, 56'h0, 7'd0, 56'h0, 64'h0, 4'd0},
        // R1: root width 31 above 30
        '{64'h0, 56'h1000, 5'd31, 7'd30, 1'b1, 3'b001, 56'h0, 7'd0, 56'h0, 64'h0, 4'd0},
        // R8: self-referencing table
        '{64'h0, 56'h8000, 5'd5, 7'd64, 1'b1, 3'b100, 56'h0, 7'd0, 56'h0, 64'h0, 4'd8},
        // R4 R6: three levels with widths 9,5,6
        '{64'hC22555, 56'h1000, 5'd9, 7'd30, 1'b0, 3'b000, 56'h77777155, 7'd10, 56'h5048, 64'hC000_0000_7777_7000, 4'd3},
        // R11: high ea bits set, same as first
        '{64'h0000_0100_0060_5456, 56'h1000, 5'd9, 7'd30, 1'b0, 3'b000, 56'hABCDE456, 7'd12, 56'h2028, 64'hC000_0000_ABCD_E000, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] ea = '0;
    logic [55:0] root_base = '0;
    logic [4:0]  root_nls = '0;
    logic [6:0]  total_bits = '0;
    logic        rd_req;
    logic [55:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic        busy, done, fault;
    logic [2:0]  cause;
    logic [55:0] real_addr, leaf_addr;
    logic [6:0]  page_size;
    logic [63:0] leaf_entry;

    int n_chk = 0;
    int n_bad = 0;
    int nreads = 0;
    int lat = 0;
    int wcnt = 0;

    always #(CLK_T/2) clk = ~clk;

    rpw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .root_base(root_base),
        .root_nls(root_nls), .total_bits(total_bits), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done), .fault(fault),
        .cause(cause), .real_addr(real_addr), .page_size(page_size),
        .leaf_entry(leaf_entry), .leaf_addr(leaf_addr)
    );

    function automatic logic [63:0] mem_rd(input logic [55:0] a);
        case (a)
            56'h1018: return 64'h8000_0000_0000_2009;
            56'h2028: return 64'hC000_0000_ABCD_E000;
            56'h1038: return 64'hC000_0000_1234_5000;
            56'h1020: return 64'h8000_0000_0000_3004;
            56'h1028: return 64'h8000_0000_0000_3016;
            56'h8000: return 64'h8000_0000_0000_8005;
            56'h1030: return 64'h8000_0000_0000_4005;
            56'h4010: return 64'h8000_0000_0000_5006;
            56'h5048: return 64'hC000_0000_7777_7000;
            default:  return 64'h0;
        endcase
    endfunction

    // Memory: answers a held request after lat idle cycles, one cycle of rd_valid.
    always @(negedge clk) begin
        if (rd_valid) begin
            rd_valid = 1'b0;
            wcnt = 0;
        end else if (rd_req) begin
            if (wcnt >= lat) begin
                rd_valid = 1'b1;
                rd_data = mem_rd(rd_addr);
                nreads++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        start = 1'b1; ea = v.ea; root_base = v.base; root_nls = v.nls; total_bits = v.total;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic check_result(input string tag, input vec_t v, input int rds);
        chk({tag, " done"}, 64'(done), 64'd1);
        chk({tag, " fault R9"}, 64'(fault), 64'(v.flt));
        chk({tag, " cause R9"}, 64'(cause), 64'(v.cause));
        chk({tag, " reads R2"}, 64'(rds), 64'(v.nrd));
        if (!v.flt) begin
            chk({tag, " real_addr R6"}, 64'(real_addr), 64'(v.ra));
            chk({tag, " page_size R6"}, 64'(page_size), 64'(v.psize));
            chk({tag, " leaf_addr R7"}, 64'(leaf_addr), 64'(v.laddr));
            chk({tag, " leaf_entry R7"}, leaf_entry, v.lent);
        end
    endtask

    initial begin
        #(CLK_T * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 busy", 64'(busy), 64'd0);
        chk("R12 done", 64'(done), 64'd0);
        chk("R12 rd_req", 64'(rd_req), 64'd0);

        for (int i = 0; i < NV; i++) begin
            r0 = nreads;
            launch(VECS[i]);
            wait_done(cyc);
            check_result($sformatf("vec%0d", i), VECS[i], nreads - r0);
            if (VECS[i].nrd == 0) chk("R1 latency", 64'(cyc), 64'd1);
            @(negedge clk);
            chk("R9 done pulse", 64'(done), 64'd0);
        end

        // R2: slow memory, request must be held
        lat = 3;
        r0 = nreads;
        launch(VECS[0]);
        wait_done(cyc);
        check_result("slow R2", VECS[0], nreads - r0);
        lat = 0;

        // R10: second start during a walk is ignored
        r0 = nreads;
        launch(VECS[9]);
        @(negedge clk);
        start = 1'b1; ea = VECS[1].ea; root_nls = 5'd4;
        @(negedge clk);
        start = 1'b0;
        chk("R10 still busy", 64'(busy), 64'd1);
        wait_done(cyc);
        check_result("busy R10", VECS[9], nreads - r0);
        @(negedge clk);
        chk("R10 idle after", 64'(busy), 64'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule